// File: doc/BRIEF.md
# Wired-Interrupt to Message Bridge

This block turns a bank of wired interrupt lines into posted message-signalled interrupt writes. Each input line is one global interrupt pin. A line becomes pending when its trigger condition is met. For a pending pin the bridge issues one write on an outbound valid/ready port. The write address is a doorbell address fixed at build time. The data word packs an event ID and a device ID, both programmed per pin by software.

Pins are numbered globally, and the first 64 numbers are reserved. The usable pins are grouped into nodes of 128, and each node owns a 4 KiB register window. That window holds the per-pin trigger-type bits and the per-pin vector registers, addressed by the pin's index inside its node. A separate clear array, addressed by global pin number, lets software acknowledge a pin once its handler has run. The number of nodes is a parameter; the default of two covers pins 64 to 319.

Top module: `irq_msg_bridge`

## Requirements
- R1: After reset, no message is offered, every trigger-type bit reads 0 and every vector register reads 0.
- R2: The vector register of global pin g (64 ≤ g) sits at byte address n·0x1000 + 0x200 + 4·l, where n = (g−64)/128 + 1 and l = (g−64) mod 128. Bits [11:0] hold the device ID and bits [21:12] the event ID. Bits [31:22] read as 0.
- R3: The trigger-type bit of pin g is bit (l mod 32) of the word at n·0x1000 + 4·(l/32). Each word is fully writable and reads back as written.
- R4: With a type bit of 0 (rising edge), a 0→1 change on the pin's input makes it pending. Keeping the input high produces no further message.
- R5: With a type bit of 1 (level high), a high input makes the pin pending. If the input is still high when the pin is cleared, the pin becomes pending again and sends a new message.
- R6: Writing 1 to bit (g mod 32) of the word at 0xA000 + 4·(g/32) clears the pending state of pin g. Writing 0 there has no effect.
- R7: Each message carries the fixed doorbell address and the data word {10'b0, event ID, device ID}. It stays valid with unchanged data until ready is seen.
- R8: When several pins wait to be sent, they are served round-robin, starting from the pin after the last one sent and wrapping around.
- R9: Reads of unmapped or misaligned offsets, node 0, nodes beyond the last, and the whole clear array return 0. Writes there change no register. Clear words for reserved pins 0–63 are ignored.
- R10: A pending pin sends exactly one message until it is cleared, whatever its input does in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_in | input | NUM_NODES·128 | Interrupt lines; bit i is global pin 64+i |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_addr | output | MSG_AW | Doorbell address |
| msg_data | output | 32 | {event ID, device ID} |

## Verification
A wrong pending or sent bit shows at the message port within two cycles of the input change or the clear write. It appears either as a missing message or as a duplicate message for the same pin. A broken round-robin pointer shows as a different order of device IDs on the very next group of simultaneous requests. A decode fault in the register window shows at once as a wrong read-back, or later as a message that carries another pin's IDs.

// File: rtl/irqbr_pkg.sv
package irqbr_pkg;

    localparam int unsigned REG_AW        = 16;
    localparam int unsigned DATA_W        = 32;
    localparam int unsigned EVT_W         = 10;
    localparam int unsigned DEV_W         = 12;
    localparam int unsigned VEC_W         = EVT_W + DEV_W;
    localparam int unsigned PINS_PER_NODE = 128;
    localparam int unsigned FIRST_PIN     = 64;
    localparam int unsigned WORD_BITS     = 32;
    localparam int unsigned TYPE_WORDS    = PINS_PER_NODE / WORD_BITS;
    localparam int unsigned FIRST_WORD    = FIRST_PIN / WORD_BITS;
    localparam int unsigned VEC_OFS       = 32'h200;
    localparam int unsigned CLR_PAGE      = 32'hA;

    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [DEV_W-1:0] dev;
    } vec_t;

    typedef enum logic [1:0] {RG_NONE, RG_TYPE, RG_VEC, RG_CLR} region_e;

    function automatic region_e region_of(input logic [REG_AW-1:0] a,
                                          input int unsigned nodes);
        int unsigned page, off;
        page = 32'(a[15:12]);
        off  = 32'(a[11:0]);
        region_of = RG_NONE;
        if (a[1:0] == 2'b00) begin
            if (page >= 1 && page <= nodes) begin
                if (off < TYPE_WORDS * 4)
                    region_of = RG_TYPE;
                else if (off >= VEC_OFS && off < VEC_OFS + PINS_PER_NODE * 4)
                    region_of = RG_VEC;
            end else if (page == CLR_PAGE && off / 4 >= FIRST_WORD &&
                         off / 4 < FIRST_WORD + nodes * TYPE_WORDS) begin
                region_of = RG_CLR;
            end
        end
    endfunction

    function automatic int unsigned type_word_of(input logic [REG_AW-1:0] a);
        return (32'(a[15:12]) - 1) * TYPE_WORDS + 32'(a[11:2]);
    endfunction

    function automatic int unsigned vec_pin_of(input logic [REG_AW-1:0] a);
        return (32'(a[15:12]) - 1) * PINS_PER_NODE + 32'(a[11:2]) - VEC_OFS / 4;
    endfunction

    function automatic int unsigned clr_word_of(input logic [REG_AW-1:0] a);
        return 32'(a[11:2]) - FIRST_WORD;
    endfunction

endpackage

// File: rtl/irqbr_regs.sv
module irqbr_regs
    import irqbr_pkg::*;
#(
    parameter int unsigned NUM_NODES = 2,
    localparam int unsigned NPINS  = NUM_NODES * PINS_PER_NODE,
    localparam int unsigned NWORDS = NPINS / WORD_BITS,
    localparam int unsigned PIW    = $clog2(NPINS),
    localparam int unsigned WIW    = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NPINS-1:0]  type_o,
    output vec_t [NPINS-1:0]  vec_o,
    output logic [NPINS-1:0]  clr_o
);

    logic [NWORDS-1:0][WORD_BITS-1:0] type_w;
    logic [NWORDS-1:0][WORD_BITS-1:0] clr_w;
    vec_t [NPINS-1:0]                 vec_q;
    region_e                          rg;
    logic [PIW-1:0]                   vidx;
    logic [WIW-1:0]                   tidx, cidx;

    assign rg   = region_of(reg_addr, NUM_NODES);
    assign vidx = PIW'(vec_pin_of(reg_addr));
    assign tidx = WIW'(type_word_of(reg_addr));
    assign cidx = WIW'(clr_word_of(reg_addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            type_w <= '0;
            vec_q  <= '0;
        end else if (reg_wen) begin
            case (rg)
                RG_TYPE: type_w[tidx] <= reg_wdata;
                RG_VEC:  vec_q[vidx]  <= vec_t'(reg_wdata[VEC_W-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_w = '0;
        if (reg_wen && rg == RG_CLR)
            clr_w[cidx] = reg_wdata;
    end

    always_comb begin
        reg_rdata = '0;
        case (rg)
            RG_TYPE: reg_rdata = type_w[tidx];
            RG_VEC:  reg_rdata[VEC_W-1:0] = vec_q[vidx];
            default: ;
        endcase
    end

    assign type_o = type_w;
    assign vec_o  = vec_q;
    assign clr_o  = clr_w;

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && (rg == RG_CLR || rg == RG_NONE)) |=> ($stable(type_w) && $stable(vec_q)));

endmodule

// File: rtl/irqbr_pend.sv
module irqbr_pend #(
    parameter int unsigned NPINS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] irq_in,
    input  logic [NPINS-1:0] type_i,
    input  logic [NPINS-1:0] clr_i,
    input  logic [NPINS-1:0] take_i,
    output logic [NPINS-1:0] req_o
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic prev_q, pend_q, sent_q, hit;

        // level mode: input high; edge mode: input rose since last cycle
        assign hit = type_i[i] ? irq_in[i] : (irq_in[i] & ~prev_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                sent_q <= 1'b0;
            end else begin
                prev_q <= irq_in[i];
                pend_q <= hit | (pend_q & ~clr_i[i]);
                sent_q <= ~clr_i[i] & (sent_q | take_i[i]);
            end
        end

        assign req_o[i] = pend_q & ~sent_q;
    end

    // R10
    take_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i & ~req_o) == '0);

endmodule

// File: rtl/irqbr_arb.sv
module irqbr_arb
    import irqbr_pkg::*;
#(
    parameter int unsigned NPINS  = 256,
    parameter int unsigned MSG_AW = 32,
    parameter logic [MSG_AW-1:0] DOORBELL = '0,
    localparam int unsigned PIW = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  req_i,
    input  vec_t [NPINS-1:0]  vec_i,
    output logic [NPINS-1:0]  take_o,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [MSG_AW-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);

    logic [PIW-1:0] ptr_q, sel;
    logic           found, load;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int j = 0; j < NPINS; j++) begin
            if (!found && req_i[j] && PIW'(j) > ptr_q) begin
                sel   = PIW'(j);
                found = 1'b1;
            end
        end
        for (int j = 0; j < NPINS; j++) begin
            if (!found && req_i[j]) begin
                sel   = PIW'(j);
                found = 1'b1;
            end
        end
    end

    assign load   = found && (!msg_valid || msg_ready);
    assign take_o = load ? (NPINS'(1) << sel) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_data  <= '0;
            ptr_q     <= PIW'(NPINS - 1);
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_data  <= {{(DATA_W - VEC_W){1'b0}}, vec_i[sel]};
            ptr_q     <= sel;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    assign msg_addr = DOORBELL;

    // R7
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data)));

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_o));

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !msg_valid);

endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
    import irqbr_pkg::*;
#(
    parameter int unsigned NUM_NODES = 2,
    parameter int unsigned MSG_AW    = 32,
    parameter logic [MSG_AW-1:0] DOORBELL = 32'hFEE0_1040
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [15:0]                        reg_addr,
    input  logic                               reg_wen,
    input  logic [31:0]                        reg_wdata,
    output logic [31:0]                        reg_rdata,
    input  logic [NUM_NODES*PINS_PER_NODE-1:0] irq_in,
    output logic                               msg_valid,
    input  logic                               msg_ready,
    output logic [MSG_AW-1:0]                  msg_addr,
    output logic [31:0]                        msg_data
);

    localparam int unsigned NPINS = NUM_NODES * PINS_PER_NODE;

    logic [NPINS-1:0] type_bits, clr_bits, req_bits, take_bits;
    vec_t [NPINS-1:0] vecs;

    irqbr_regs #(.NUM_NODES(NUM_NODES)) u_regs (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .type_o(type_bits), .vec_o(vecs), .clr_o(clr_bits)
    );

    irqbr_pend #(.NPINS(NPINS)) u_pend (
        .clk(clk), .rst(rst),
        .irq_in(irq_in), .type_i(type_bits), .clr_i(clr_bits),
        .take_i(take_bits), .req_o(req_bits)
    );

    irqbr_arb #(.NPINS(NPINS), .MSG_AW(MSG_AW), .DOORBELL(DOORBELL)) u_arb (
        .clk(clk), .rst(rst),
        .req_i(req_bits), .vec_i(vecs), .take_o(take_bits),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

endmodule

// File: tb/irq_msg_bridge_test.sv
`timescale 1ns/1ps
module irq_msg_bridge_test;

    localparam int NPINS = 256;
    localparam logic [31:0] DB = 32'hFEE0_1040;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [15:0]      reg_addr = '0;
    logic             reg_wen = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [NPINS-1:0] irq_in = '0;
    logic             msg_valid;
    logic             msg_ready = 1'b0;
    logic [31:0]      msg_addr;
    logic [31:0]      msg_data;

    int checks = 0;
    int errors = 0;

    irq_msg_bridge #(.NUM_NODES(2), .MSG_AW(32), .DOORBELL(DB)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [15:0] wa;
        logic [31:0] wd;
        logic [15:0] ra;
        logic [31:0] ex;
        logic [7:0]  rq;
    } tv_t;

    localparam tv_t TV [12] = '{
        '{16'h1200, 32'hFFFF_FFFF, 16'h1200, 32'h003F_FFFF, 8'd2}, // R2 pin 64, upper bits dropped
        '{16'h2220, 32'h0015_5ABC, 16'h2220, 32'h0015_5ABC, 8'd2}, // R2 pin 200
        '{16'h1004, 32'h0000_0010, 16'h1004, 32'h0000_0010, 8'd3}, // R3 pin 100
        '{16'h200C, 32'hFFFF_0000, 16'h200C, 32'hFFFF_0000, 8'd3}, // R3 node 2 last word
        '{16'h0200, 32'h1234_5678, 16'h1200, 32'h003F_FFFF, 8'd9}, // R9 node 0 ignored
        '{16'h3220, 32'h1234_5678, 16'h3220, 32'h0000_0000, 8'd9}, // R9 node 3 absent
        '{16'h1100, 32'hDEAD_BEEF, 16'h1100, 32'h0000_0000, 8'd9}, // R9 gap in window
        '{16'h1010, 32'hFFFF_FFFF, 16'h1010, 32'h0000_0000, 8'd9}, // R9 past type words
        '{16'hA008, 32'hFFFF_FFFF, 16'hA008, 32'h0000_0000, 8'd9}, // R9 clear reads zero
        '{16'hA000, 32'hFFFF_FFFF, 16'h1200, 32'h003F_FFFF, 8'd9}, // R9 reserved clear word
        '{16'h1202, 32'h0000_0001, 16'h1200, 32'h003F_FFFF, 8'd9}, // R9 misaligned write
        '{16'h0000, 32'hFFFF_FFFF, 16'h2220, 32'h0015_5ABC, 8'd9}  // R9 node 0 type word
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic get_msg(output bit got, output logic [31:0] d, output logic [31:0] a);
        got = 1'b0;
        d = '0;
        a = '0;
        for (int k = 0; k < 40 && !got; k++) begin
            @(negedge clk);
            if (msg_valid) begin
                got = 1'b1;
                d = msg_data;
                a = msg_addr;
                msg_ready = 1'b1;
                @(negedge clk);
                msg_ready = 1'b0;
            end
        end
    endtask

    task automatic quiet(input int n, output bit q);
        q = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) q = 1'b0;
        end
    endtask

    task automatic expect_msg(input string rq, input logic [31:0] exp);
        bit got;
        logic [31:0] d, a;
        get_msg(got, d, a);
        chk(got, rq, "message present", {31'b0, got}, 32'h1);
        chk(d == exp, rq, "message data", d, exp);
        chk(a == DB, "R7", "doorbell address", a, DB);
    endtask

    task automatic expect_quiet(input string rq, input int n);
        bit q;
        quiet(n, q);
        chk(q, rq, "no message", {31'b0, !q}, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        chk(!msg_valid, "R1", "valid after reset", {31'b0, msg_valid}, 32'h0);
        rd(16'h1200, v); chk(v == 0, "R1", "vector after reset", v, 32'h0);

        for (int t = 0; t < 12; t++) begin
            wr(TV[t].wa, TV[t].wd);
            rd(TV[t].ra, v);
            chk(v == TV[t].ex, $sformatf("R%0d", TV[t].rq),
                $sformatf("table entry %0d", t), v, TV[t].ex);
        end

        do_reset();
        // R1 registers back to zero
        rd(16'h1200, v); chk(v == 0, "R1", "vector cleared by reset", v, 32'h0);
        rd(16'h1004, v); chk(v == 0, "R1", "type cleared by reset", v, 32'h0);
        chk(!msg_valid, "R1", "valid after second reset", {31'b0, msg_valid}, 32'h0);

        // R4 edge mode, pin 70 (bit 6)
        wr(16'h1218, 32'h0015_5ABC);
        @(negedge clk); irq_in[6] = 1'b1;
        repeat (3) @(negedge clk);
        chk(msg_valid && msg_data == 32'h0015_5ABC, "R4", "edge raised message",
            msg_data, 32'h0015_5ABC);
        repeat (4) @(negedge clk);
        // R7 held while not ready
        chk(msg_valid && msg_data == 32'h0015_5ABC, "R7", "message held stable",
            msg_data, 32'h0015_5ABC);
        expect_msg("R4", 32'h0015_5ABC);
        expect_quiet("R4", 10);
        @(negedge clk); irq_in[6] = 1'b0;
        @(negedge clk); irq_in[6] = 1'b1;
        expect_quiet("R10", 10);
        wr(16'hA008, 32'h0000_0040);
        expect_quiet("R6", 5);
        @(negedge clk); irq_in[6] = 1'b0;
        @(negedge clk); irq_in[6] = 1'b1;
        expect_msg("R6", 32'h0015_5ABC);
        @(negedge clk); irq_in[6] = 1'b0;
        wr(16'hA008, 32'h0000_0040);

        // R5 level mode, pin 300 (bit 236, node 2 local 108)
        wr(16'h200C, 32'h0000_1000);
        rd(16'h200C, v); chk(v == 32'h0000_1000, "R3", "type readback", v, 32'h0000_1000);
        wr(16'h23B0, 32'h003F_F001);
        @(negedge clk); irq_in[236] = 1'b1;
        expect_msg("R5", 32'h003F_F001);
        expect_quiet("R10", 10);
        wr(16'hA024, 32'h0000_0000);
        expect_quiet("R6", 10);
        wr(16'hA024, 32'h0000_1000);
        expect_msg("R5", 32'h003F_F001);
        @(negedge clk); irq_in[236] = 1'b0;
        wr(16'hA024, 32'h0000_1000);
        expect_quiet("R5", 10);

        // R8 round robin: last sent was bit 236, so 255, then 1, then 130
        wr(16'h1204, 32'h0004_2041);
        wr(16'h2208, 32'h000C_30C2);
        wr(16'h23FC, 32'h0014_013F);
        @(negedge clk);
        irq_in[1] = 1'b1; irq_in[130] = 1'b1; irq_in[255] = 1'b1;
        repeat (3) @(negedge clk);
        expect_msg("R8", 32'h0014_013F);
        expect_msg("R8", 32'h0004_2041);
        expect_msg("R8", 32'h000C_30C2);
        expect_quiet("R10", 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule